// File: doc/BRIEF.md
# Floating-Point Operate Group Decoder

This block sits in the issue stage of a processor core. For each instruction of the first floating-point operate group it decodes the 9-bit operation field and the three 5-bit register specifiers. It reports an operation class and a precision for each operand. It also turns every specifier into a 6-bit physical index for a 64-entry file of 32-bit registers. Double and quad operands keep their even/odd bit in place and take bit 0 of the field again as the top index bit. Single and integer operands use the field as it stands. The block also gives the indices of the successive double words of a multi-register destination.

The three sign-only moves (copy, negate, absolute value) run in the block itself on a 32-bit source word. They return a status word whose trap-type and current-exception fields are cleared. Arithmetic and conversion operations are only classified and routed. Quad forms and every operation code not recognised raise a floating-point-disabled trap. A trap suppresses the register-file write.

Decode results are captured on the rising clock edge when `in_vld` is high. A two-state controller drives `out_vld`:

- `ST_IDLE`: no valid result.
- `ST_OUT`: a result is presented.

The controller has four transitions:

- `ST_IDLE` to `ST_OUT` on `in_vld`.
- `ST_OUT` to `ST_OUT` on `in_vld`, for back-to-back issue.
- `ST_OUT` to `ST_IDLE` when `in_vld` is low.
- `ST_IDLE` to `ST_IDLE` when `in_vld` is low.

Reset forces `ST_IDLE`.

Top module: `fpop_decode_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears `out_vld`, every index, class, precision, `dst_grp`, `trap_fpd`, `rf_we`, `stat_we`, `result_word` and `stat_out` to zero at that edge.
- R2: `in_vld` high at a rising edge makes `out_vld` high after that edge, and the outputs then show the decode of the inputs sampled at that edge. `in_vld` low at an edge makes `out_vld` low after it.
- R3: An operand of precision single (code 00) or integer-in-FP-register (code 11) gets physical index {1'b0, field}.
- R4: An operand of precision double (code 01) or quad (code 10) gets physical index {field[0], field}, with field[0] also kept in bit 0.
- R5: Bits [6N+5:6N] of `dst_grp` hold (`idx_rd` + 2N) mod 64 for N from 0 to GRP_N-1.
- R6: Operation 0x01 is class 0 and returns `src_word` unchanged. Operation 0x05 is class 1 and returns it with bit 31 inverted. Operation 0x09 is class 2 and returns it with bit 31 cleared. All three are single-precision on source 2 and the destination.
- R7: For the three sign-only moves, `stat_we` is 1 and `stat_out` equals `stat_in` with bits 16:14 and 4:0 cleared. For every other operation `stat_we` is 0, `stat_out` equals `stat_in` and `result_word` is 0.
- R8: Operations 0x29, 0x41, 0x45, 0x49 and 0x4D are classes 3, 4, 5, 6 and 7 (square root, add, subtract, multiply, divide) at single precision. Operations 0x2A, 0x42, 0x46, 0x4A and 0x4E are the same classes at double precision. The operand precision applies to both sources and the destination. Square root reports source 1 as single.
- R9: Operations 0x03, 0x07, 0x0B, 0x2B, 0x43, 0x47, 0x4B and 0x4F raise `trap_fpd`, report class 15 and report quad precision on all three operands.
- R10: Operation 0x69 is class 8 and reads two single sources into a double destination. Operation 0xC6 is class 9 and reads a double source 2 into a single destination. Operation 0xC9 is class 9 and reads a single source 2 into a double destination.
- R11: Operations 0xC4 and 0xC8 are class 10 and read an integer source 2 into a single or a double destination respectively. Operations 0xD1 and 0xD2 are class 11 and read a single or a double source 2 respectively into an integer destination.
- R12: Any other operation code raises `trap_fpd`, reports class 15 and reports single precision on all operands.
- R13: `rf_we` is 0 whenever `trap_fpd` is 1, and 1 for every decoded operation that does not trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Capture strobe for the instruction fields |
| op_code | input | 9 | Operation field |
| rd_fld | input | FLD_W | Destination specifier |
| rs1_fld | input | FLD_W | Source 1 specifier |
| rs2_fld | input | FLD_W | Source 2 specifier |
| src_word | input | WORD_W | Source-2 operand for the sign-only moves |
| stat_in | input | STAT_W | Current status register |
| out_vld | output | 1 | Decode result valid |
| op_class | output | 4 | Operation class code |
| prec_rs1 | output | 2 | Source 1 precision code |
| prec_rs2 | output | 2 | Source 2 precision code |
| prec_rd | output | 2 | Destination precision code |
| idx_rs1 | output | FLD_W+1 | Source 1 physical index |
| idx_rs2 | output | FLD_W+1 | Source 2 physical index |
| idx_rd | output | FLD_W+1 | Destination physical index |
| dst_grp | output | GRP_N*(FLD_W+1) | Indices of the destination's successive double words |
| trap_fpd | output | 1 | Floating-point-disabled trap |
| rf_we | output | 1 | Register-file write enable |
| result_word | output | WORD_W | Result of a sign-only move |
| stat_we | output | 1 | Status register write enable |
| stat_out | output | STAT_W | Updated status register |

## Verification
The bench builds the block with FLD_W=5, WORD_W=32, STAT_W=32 and GRP_N=8. These are the sizes the operation encodings and status bit positions assume. With them, a double destination at field 31 maps to index 63, so the whole eight-entry destination group wraps past the top of the 64-entry file and its modulo arithmetic is exercised. A status word of all ones makes every cleared bit visible, and source words with the sign bit set and clear exercise the negate and absolute-value paths.

// File: rtl/fpd_pkg.sv
package fpd_pkg;

    localparam int OPC_W = 9;

    typedef enum logic [3:0] {
        CL_MOV   = 4'd0,
        CL_NEG   = 4'd1,
        CL_ABS   = 4'd2,
        CL_SQRT  = 4'd3,
        CL_ADD   = 4'd4,
        CL_SUB   = 4'd5,
        CL_MUL   = 4'd6,
        CL_DIV   = 4'd7,
        CL_MULW  = 4'd8,
        CL_FCVT  = 4'd9,
        CL_ITOF  = 4'd10,
        CL_FTOI  = 4'd11,
        CL_TRAP  = 4'd15
    } op_class_e;

    typedef enum logic [1:0] {
        PR_SGL  = 2'b00,
        PR_DBL  = 2'b01,
        PR_QUAD = 2'b10,
        PR_INT  = 2'b11
    } prec_e;

    typedef struct packed {
        op_class_e cls;
        prec_e     p_rs1;
        prec_e     p_rs2;
        prec_e     p_rd;
        logic      trap;
        logic      sign_op;
    } dec_t;

endpackage

// File: rtl/fpd_classify.sv
module fpd_classify
    import fpd_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    output dec_t             dec
);
    // Build a non-trapping decode record.
    function automatic dec_t mk(op_class_e c, prec_e a, prec_e b, prec_e d, logic s);
        dec_t r;
        r.cls     = c;
        r.p_rs1   = a;
        r.p_rs2   = b;
        r.p_rd    = d;
        r.trap    = 1'b0;
        r.sign_op = s;
        return r;
    endfunction

    function automatic dec_t mk_trap(prec_e p);
        dec_t r;
        r.cls     = CL_TRAP;
        r.p_rs1   = p;
        r.p_rs2   = p;
        r.p_rd    = p;
        r.trap    = 1'b1;
        r.sign_op = 1'b0;
        return r;
    endfunction

    always_comb begin
        unique case (opc)
            // sign-only moves, executed locally
            9'h001: dec = mk(CL_MOV,  PR_SGL, PR_SGL, PR_SGL, 1'b1);
            9'h005: dec = mk(CL_NEG,  PR_SGL, PR_SGL, PR_SGL, 1'b1);
            9'h009: dec = mk(CL_ABS,  PR_SGL, PR_SGL, PR_SGL, 1'b1);
            // square root
            9'h029: dec = mk(CL_SQRT, PR_SGL, PR_SGL, PR_SGL, 1'b0);
            9'h02A: dec = mk(CL_SQRT, PR_SGL, PR_DBL, PR_DBL, 1'b0);
            // two-source arithmetic
            9'h041: dec = mk(CL_ADD,  PR_SGL, PR_SGL, PR_SGL, 1'b0);
            9'h042: dec = mk(CL_ADD,  PR_DBL, PR_DBL, PR_DBL, 1'b0);
            9'h045: dec = mk(CL_SUB,  PR_SGL, PR_SGL, PR_SGL, 1'b0);
            9'h046: dec = mk(CL_SUB,  PR_DBL, PR_DBL, PR_DBL, 1'b0);
            9'h049: dec = mk(CL_MUL,  PR_SGL, PR_SGL, PR_SGL, 1'b0);
            9'h04A: dec = mk(CL_MUL,  PR_DBL, PR_DBL, PR_DBL, 1'b0);
            9'h04D: dec = mk(CL_DIV,  PR_SGL, PR_SGL, PR_SGL, 1'b0);
            9'h04E: dec = mk(CL_DIV,  PR_DBL, PR_DBL, PR_DBL, 1'b0);
            // mixed precision
            9'h069: dec = mk(CL_MULW, PR_SGL, PR_SGL, PR_DBL, 1'b0);
            9'h0C6: dec = mk(CL_FCVT, PR_SGL, PR_DBL, PR_SGL, 1'b0);
            9'h0C9: dec = mk(CL_FCVT, PR_SGL, PR_SGL, PR_DBL, 1'b0);
            // integer conversions
            9'h0C4: dec = mk(CL_ITOF, PR_SGL, PR_INT, PR_SGL, 1'b0);
            9'h0C8: dec = mk(CL_ITOF, PR_SGL, PR_INT, PR_DBL, 1'b0);
            9'h0D1: dec = mk(CL_FTOI, PR_SGL, PR_SGL, PR_INT, 1'b0);
            9'h0D2: dec = mk(CL_FTOI, PR_SGL, PR_DBL, PR_INT, 1'b0);
            // quad forms trap
            9'h003, 9'h007, 9'h00B, 9'h02B,
            9'h043, 9'h047, 9'h04B, 9'h04F:
                    dec = mk_trap(PR_QUAD);
            default: dec = mk_trap(PR_SGL);
        endcase
    end
endmodule

// File: rtl/fpd_regmap.sv
module fpd_regmap
    import fpd_pkg::*;
#(
    parameter int FLD_W = 5,
    localparam int IDX_W = FLD_W + 1
) (
    input  logic [FLD_W-1:0] fld,
    input  prec_e            prec,
    output logic [IDX_W-1:0] idx
);
    // Wide operands fold their low bit into the extra top bit.
    always_comb begin
        unique case (prec)
            PR_DBL, PR_QUAD: idx = {fld[0], fld};
            default:         idx = {1'b0, fld};
        endcase
    end
endmodule

// File: rtl/fpd_signop.sv
module fpd_signop
    import fpd_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int STAT_W = 32
) (
    input  op_class_e         cls,
    input  logic              en,
    input  logic [WORD_W-1:0] src,
    input  logic [STAT_W-1:0] st_in,
    output logic [WORD_W-1:0] res,
    output logic [STAT_W-1:0] st_nxt
);
    localparam logic [WORD_W-1:0] SIGN_BIT = {1'b1, {(WORD_W-1){1'b0}}};
    // trap-type field 16:14 and current-exception field 4:0
    localparam logic [STAT_W-1:0] STAT_CLR = STAT_W'(32'h0001_C01F);

    always_comb begin
        res    = '0;
        st_nxt = st_in;
        if (en) begin
            st_nxt = st_in & ~STAT_CLR;
            unique case (cls)
                CL_NEG:  res = src ^ SIGN_BIT;
                CL_ABS:  res = src & ~SIGN_BIT;
                default: res = src;
            endcase
        end
    end
endmodule

// File: rtl/fpop_decode_unit.sv
module fpop_decode_unit
    import fpd_pkg::*;
#(
    parameter int FLD_W  = 5,
    parameter int WORD_W = 32,
    parameter int STAT_W = 32,
    parameter int GRP_N  = 8,
    localparam int IDX_W = FLD_W + 1,
    localparam int GRP_W = GRP_N * IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [8:0]        op_code,
    input  logic [FLD_W-1:0]  rd_fld,
    input  logic [FLD_W-1:0]  rs1_fld,
    input  logic [FLD_W-1:0]  rs2_fld,
    input  logic [WORD_W-1:0] src_word,
    input  logic [STAT_W-1:0] stat_in,
    output logic              out_vld,
    output logic [3:0]        op_class,
    output logic [1:0]        prec_rs1,
    output logic [1:0]        prec_rs2,
    output logic [1:0]        prec_rd,
    output logic [IDX_W-1:0]  idx_rs1,
    output logic [IDX_W-1:0]  idx_rs2,
    output logic [IDX_W-1:0]  idx_rd,
    output logic [GRP_W-1:0]  dst_grp,
    output logic              trap_fpd,
    output logic              rf_we,
    output logic [WORD_W-1:0] result_word,
    output logic              stat_we,
    output logic [STAT_W-1:0] stat_out
);
    typedef enum logic {ST_IDLE = 1'b0, ST_OUT = 1'b1} ctl_state_e;

    ctl_state_e state_q, state_d;

    dec_t              dec;
    logic [IDX_W-1:0]  m_rs1, m_rs2, m_rd;
    logic [GRP_W-1:0]  grp_n;
    logic [WORD_W-1:0] res_n;
    logic [STAT_W-1:0] st_n;

    fpd_classify u_cls (.opc(op_code), .dec(dec));

    fpd_regmap #(.FLD_W(FLD_W)) u_map_rs1 (.fld(rs1_fld), .prec(dec.p_rs1), .idx(m_rs1));
    fpd_regmap #(.FLD_W(FLD_W)) u_map_rs2 (.fld(rs2_fld), .prec(dec.p_rs2), .idx(m_rs2));
    fpd_regmap #(.FLD_W(FLD_W)) u_map_rd  (.fld(rd_fld),  .prec(dec.p_rd),  .idx(m_rd));

    // successive double words of the destination, two slots apart
    for (genvar n = 0; n < GRP_N; n++) begin : g_grp
        assign grp_n[n*IDX_W +: IDX_W] = m_rd + IDX_W'(2 * n);
    end

    fpd_signop #(.WORD_W(WORD_W), .STAT_W(STAT_W)) u_sign (
        .cls   (dec.cls),
        .en    (dec.sign_op),
        .src   (src_word),
        .st_in (stat_in),
        .res   (res_n),
        .st_nxt(st_n)
    );

    // controller: next state
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_vld ? ST_OUT : ST_IDLE;
            ST_OUT:  state_d = in_vld ? ST_OUT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // controller: state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign out_vld = (state_q == ST_OUT);

    // output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            op_class    <= '0;
            prec_rs1    <= '0;
            prec_rs2    <= '0;
            prec_rd     <= '0;
            idx_rs1     <= '0;
            idx_rs2     <= '0;
            idx_rd      <= '0;
            dst_grp     <= '0;
            trap_fpd    <= 1'b0;
            rf_we       <= 1'b0;
            result_word <= '0;
            stat_we     <= 1'b0;
            stat_out    <= '0;
        end else if (in_vld) begin
            op_class    <= dec.cls;
            prec_rs1    <= dec.p_rs1;
            prec_rs2    <= dec.p_rs2;
            prec_rd     <= dec.p_rd;
            idx_rs1     <= m_rs1;
            idx_rs2     <= m_rs2;
            idx_rd      <= m_rd;
            dst_grp     <= grp_n;
            trap_fpd    <= dec.trap;
            rf_we       <= ~dec.trap;
            result_word <= res_n;
            stat_we     <= dec.sign_op;
            stat_out    <= st_n;
        end
    end
endmodule

// File: rtl/fpd_chk.sv
module fpd_chk #(
    parameter int IDX_W  = 6,
    parameter int STAT_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              in_vld,
    input logic              out_vld,
    input logic [1:0]        prec_rs1,
    input logic [1:0]        prec_rd,
    input logic [IDX_W-1:0]  idx_rs1,
    input logic [IDX_W-1:0]  idx_rd,
    input logic              trap_fpd,
    input logic              rf_we,
    input logic              stat_we,
    input logic [STAT_W-1:0] stat_out
);
    AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);  // R2
    AST_VLD_DROPS: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld);  // R2
    AST_NARROW_IDX: assert property (@(posedge clk) disable iff (rst)
        (out_vld && (prec_rs1 == 2'b00 || prec_rs1 == 2'b11)) |-> !idx_rs1[IDX_W-1]);  // R3
    AST_WIDE_IDX: assert property (@(posedge clk) disable iff (rst)
        (out_vld && (prec_rd == 2'b01 || prec_rd == 2'b10)) |-> (idx_rd[IDX_W-1] == idx_rd[0]));  // R4
    AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (out_vld && stat_we) |-> (stat_out[16:14] == 3'b0 && stat_out[4:0] == 5'b0));  // R7
    AST_TRAP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (out_vld && trap_fpd) |-> (!rf_we && !stat_we));  // R13
endmodule

bind fpop_decode_unit fpd_chk #(.IDX_W(IDX_W), .STAT_W(STAT_W)) u_fpd_chk (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .out_vld (out_vld),
    .prec_rs1(prec_rs1),
    .prec_rd (prec_rd),
    .idx_rs1 (idx_rs1),
    .idx_rd  (idx_rd),
    .trap_fpd(trap_fpd),
    .rf_we   (rf_we),
    .stat_we (stat_we),
    .stat_out(stat_out)
);

// File: tb/test_fpop_decode_unit.sv
module test_fpop_decode_unit;
    localparam int FLD_W  = 5;
    localparam int WORD_W = 32;
    localparam int STAT_W = 32;
    localparam int GRP_N  = 8;
    localparam int IDX_W  = FLD_W + 1;
    localparam int GRP_W  = GRP_N * IDX_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_vld = 1'b0;
    logic [8:0] op_code = '0;
    logic [FLD_W-1:0] rd_fld = '0, rs1_fld = '0, rs2_fld = '0;
    logic [WORD_W-1:0] src_word = '0;
    logic [STAT_W-1:0] stat_in = '0;
    logic out_vld, trap_fpd, rf_we, stat_we;
    logic [3:0] op_class;
    logic [1:0] prec_rs1, prec_rs2, prec_rd;
    logic [IDX_W-1:0] idx_rs1, idx_rs2, idx_rd;
    logic [GRP_W-1:0] dst_grp;
    logic [WORD_W-1:0] result_word;
    logic [STAT_W-1:0] stat_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fpop_decode_unit #(.FLD_W(FLD_W), .WORD_W(WORD_W), .STAT_W(STAT_W), .GRP_N(GRP_N))
    i_fpop_decode_unit (.*);

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] map_idx(logic [4:0] f, logic [1:0] p);
        return (p == 2'b01 || p == 2'b10) ? {f[0], f} : {1'b0, f};
    endfunction

    localparam logic [31:0] ST_MASK = 32'h0001_C01F;

    // drive one instruction, sample after the capturing edge
    task automatic issue(logic [8:0] op, logic [4:0] rd, logic [4:0] r1, logic [4:0] r2,
                         logic [31:0] src, logic [31:0] st);
        @(negedge clk);
        op_code = op; rd_fld = rd; rs1_fld = r1; rs2_fld = r2;
        src_word = src; stat_in = st; in_vld = 1'b1;
        @(negedge clk);
        in_vld = 1'b0;
    endtask

    task automatic chk_dec(string req, logic [3:0] cls, logic [1:0] p1, logic [1:0] p2,
                           logic [1:0] pd, logic trap);
        chk({req, " out_vld"}, 64'(out_vld), 64'd1);
        chk({req, " class"}, 64'(op_class), 64'(cls));
        chk({req, " prec_rs1"}, 64'(prec_rs1), 64'(p1));
        chk({req, " prec_rs2"}, 64'(prec_rs2), 64'(p2));
        chk({req, " prec_rd"}, 64'(prec_rd), 64'(pd));
        chk({req, " idx_rs1"}, 64'(idx_rs1), 64'(map_idx(rs1_fld, p1)));
        chk({req, " idx_rs2"}, 64'(idx_rs2), 64'(map_idx(rs2_fld, p2)));
        chk({req, " idx_rd"}, 64'(idx_rd), 64'(map_idx(rd_fld, pd)));
        chk({req, " trap R9/R12"}, 64'(trap_fpd), 64'(trap));
        chk({req, " rf_we R13"}, 64'(rf_we), 64'(!trap));
        if (!(cls <= 4'd2)) begin
            chk({req, " stat_we R7"}, 64'(stat_we), 64'd0);
            chk({req, " stat_out R7"}, 64'(stat_out), 64'(stat_in));
            chk({req, " result R7"}, 64'(result_word), 64'd0);
        end
    endtask

    task automatic t_reset();
        chk("R1 out_vld", 64'(out_vld), 64'd0);
        chk("R1 idx_rd", 64'(idx_rd), 64'd0);
        chk("R1 dst_grp", 64'(dst_grp), 64'd0);
        chk("R1 rf_we", 64'(rf_we), 64'd0);
        chk("R1 trap", 64'(trap_fpd), 64'd0);
        chk("R1 stat", 64'({stat_we, stat_out, result_word}), 64'd0);
    endtask

    task automatic t_sign();
        logic [31:0] s;
        s = 32'h8000_0041;
        issue(9'h001, 5'd7, 5'd2, 5'd9, s, 32'hFFFF_FFFF);
        chk_dec("R6 mov", 4'd0, 2'b00, 2'b00, 2'b00, 1'b0);
        chk("R6 mov result", 64'(result_word), 64'(s));
        chk("R7 mov stat_we", 64'(stat_we), 64'd1);
        chk("R7 mov stat", 64'(stat_out), 64'(32'hFFFF_FFFF & ~ST_MASK));
        issue(9'h005, 5'd7, 5'd2, 5'd9, s, 32'h0001_C01F);
        chk_dec("R6 neg", 4'd1, 2'b00, 2'b00, 2'b00, 1'b0);
        chk("R6 neg result", 64'(result_word), 64'(32'h0000_0041));
        chk("R7 neg stat", 64'(stat_out), 64'd0);
        issue(9'h005, 5'd1, 5'd0, 5'd3, 32'h1234_5678, 32'h0000_0100);
        chk("R6 neg pos result", 64'(result_word), 64'(32'h9234_5678));
        chk("R7 neg keep", 64'(stat_out), 64'(32'h0000_0100));
        issue(9'h009, 5'd30, 5'd0, 5'd31, 32'hF000_000F, 32'hA5A5_A5A5);
        chk_dec("R6 abs", 4'd2, 2'b00, 2'b00, 2'b00, 1'b0);
        chk("R6 abs result", 64'(result_word), 64'(32'h7000_000F));
        chk("R7 abs stat", 64'(stat_out), 64'(32'hA5A5_A5A5 & ~ST_MASK));
    endtask

    task automatic t_arith();
        issue(9'h041, 5'd5, 5'd3, 5'd31, 32'hFFFF_FFFF, 32'h0000_001F);
        chk_dec("R8 adds R3", 4'd4, 2'b00, 2'b00, 2'b00, 1'b0);
        chk("R3 single rs2 literal", 64'(idx_rs2), 64'd31);
        issue(9'h042, 5'd5, 5'd3, 5'd30, '0, '0);
        chk_dec("R8 addd R4", 4'd4, 2'b01, 2'b01, 2'b01, 1'b0);
        chk("R4 double rd literal", 64'(idx_rd), 64'd37);
        chk("R4 double rs1 literal", 64'(idx_rs1), 64'd35);
        chk("R4 double rs2 literal", 64'(idx_rs2), 64'd30);
        issue(9'h045, 5'd1, 5'd2, 5'd3, '0, '0);  chk_dec("R8 subs", 4'd5, 2'b00, 2'b00, 2'b00, 1'b0);
        issue(9'h046, 5'd1, 5'd2, 5'd3, '0, '0);  chk_dec("R8 subd", 4'd5, 2'b01, 2'b01, 2'b01, 1'b0);
        issue(9'h049, 5'd9, 5'd11, 5'd13, '0, '0); chk_dec("R8 muls", 4'd6, 2'b00, 2'b00, 2'b00, 1'b0);
        issue(9'h04A, 5'd9, 5'd11, 5'd13, '0, '0); chk_dec("R8 muld", 4'd6, 2'b01, 2'b01, 2'b01, 1'b0);
        issue(9'h04D, 5'd17, 5'd19, 5'd21, '0, '0); chk_dec("R8 divs", 4'd7, 2'b00, 2'b00, 2'b00, 1'b0);
        issue(9'h04E, 5'd17, 5'd19, 5'd21, '0, '0); chk_dec("R8 divd", 4'd7, 2'b01, 2'b01, 2'b01, 1'b0);
        issue(9'h029, 5'd3, 5'd5, 5'd7, '0, '0);  chk_dec("R8 sqrts", 4'd3, 2'b00, 2'b00, 2'b00, 1'b0);
        issue(9'h02A, 5'd3, 5'd5, 5'd7, '0, '0);  chk_dec("R8 sqrtd", 4'd3, 2'b00, 2'b01, 2'b01, 1'b0);
    endtask

    task automatic t_group();
        logic [5:0] e;
        issue(9'h042, 5'd31, 5'd0, 5'd0, '0, '0);
        chk("R5 rd base", 64'(idx_rd), 64'd63);
        for (int n = 0; n < GRP_N; n++) begin
            e = 6'((63 + 2 * n) % 64);
            chk("R5 group wrap", 64'(dst_grp[n*IDX_W +: IDX_W]), 64'(e));
        end
        issue(9'h041, 5'd4, 5'd0, 5'd0, '0, '0);
        for (int n = 0; n < GRP_N; n++)
            chk("R5 group single", 64'(dst_grp[n*IDX_W +: IDX_W]), 64'(4 + 2 * n));
    endtask

    task automatic t_mixed();
        issue(9'h069, 5'd3, 5'd7, 5'd9, '0, '0);  chk_dec("R10 smuld", 4'd8, 2'b00, 2'b00, 2'b01, 1'b0);
        issue(9'h0C6, 5'd3, 5'd7, 5'd9, '0, '0);  chk_dec("R10 dtos", 4'd9, 2'b00, 2'b01, 2'b00, 1'b0);
        issue(9'h0C9, 5'd3, 5'd7, 5'd9, '0, '0);  chk_dec("R10 stod", 4'd9, 2'b00, 2'b00, 2'b01, 1'b0);
    endtask

    task automatic t_intcvt();
        issue(9'h0C4, 5'd11, 5'd1, 5'd13, '0, '0); chk_dec("R11 itos", 4'd10, 2'b00, 2'b11, 2'b00, 1'b0);
        issue(9'h0C8, 5'd11, 5'd1, 5'd13, '0, '0); chk_dec("R11 itod", 4'd10, 2'b00, 2'b11, 2'b01, 1'b0);
        issue(9'h0D1, 5'd11, 5'd1, 5'd13, '0, '0); chk_dec("R11 stoi", 4'd11, 2'b00, 2'b00, 2'b11, 1'b0);
        issue(9'h0D2, 5'd11, 5'd1, 5'd13, '0, '0); chk_dec("R11 dtoi", 4'd11, 2'b00, 2'b01, 2'b11, 1'b0);
    endtask

    task automatic t_traps();
        logic [8:0] q [8] = '{9'h003, 9'h007, 9'h00B, 9'h02B, 9'h043, 9'h047, 9'h04B, 9'h04F};
        logic [8:0] u [5] = '{9'h000, 9'h002, 9'h081, 9'h0D3, 9'h1FF};
        foreach (q[i]) begin
            issue(q[i], 5'd5, 5'd3, 5'd1, 32'hDEAD_BEEF, 32'hFFFF_FFFF);
            chk_dec("R9 quad trap", 4'd15, 2'b10, 2'b10, 2'b10, 1'b1);
        end
        foreach (u[i]) begin
            issue(u[i], 5'd5, 5'd3, 5'd1, 32'hDEAD_BEEF, 32'h0000_FFFF);
            chk_dec("R12 unlisted trap", 4'd15, 2'b00, 2'b00, 2'b00, 1'b1);
        end
    endtask

    task automatic t_timing();
        issue(9'h041, 5'd1, 5'd1, 5'd1, '0, '0);
        @(negedge clk);
        chk("R2 vld drops", 64'(out_vld), 64'd0);
        chk("R2 hold rd", 64'(idx_rd), 64'd1);
        @(negedge clk);
        op_code = 9'h042; rd_fld = 5'd3; in_vld = 1'b1;
        @(negedge clk);
        chk("R2 b2b first", 64'({out_vld, idx_rd}), 64'({1'b1, 6'd35}));
        op_code = 9'h041; rd_fld = 5'd9;
        @(negedge clk);
        in_vld = 1'b0;
        chk("R2 b2b second", 64'({out_vld, idx_rd}), 64'({1'b1, 6'd9}));
        @(negedge clk);
        chk("R2 idle after", 64'(out_vld), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_sign();
        t_arith();
        t_group();
        t_mixed();
        t_intcvt();
        t_traps();
        t_timing();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule